// File: doc/BRIEF.md
# Processor Init Pulse and Address-Bit-20 Mask Controller

This block drives the legacy sideband outputs that reset the processor and mask its address bit 20. It collects initialization requests from several internal sources and from an external keyboard-controller reset line. It turns any accepted request into a single active-low init pulse of fixed length. The same pulse is also driven on a second, cycle-identical output for the firmware memory device.

The keyboard-controller line is asynchronous and active low. It passes through a two-flop synchronizer, and only its falling edge counts, so a line held low yields one pulse. A falling edge seen while the sleep-transition status input is high is dropped. A request that arrives while a pulse is running merges into that pulse. The address-bit-20 mask output is active low. It is asserted when a software-written mask bit (bit 1 of the legacy system-control port) is set or when the external gate input is high.

Top module: `cpu_init_a20_ctl`

## Requirements
- R1: After reset, init_n and init_fw_n are high, the stored mask bit is 0, and a20m_n is high while a20_gate is low.
- R2: When any bit of int_req is high at a rising edge while no pulse is running, init_n goes low after that edge and stays low for exactly 16 clock cycles.
- R3: kbc_rst_n is sampled through two flops. If it is first sampled low at edge E0 after being high, init_n goes low after edge E2, provided no pulse is running.
- R4: kbc_rst_n held low for any length of time produces exactly one pulse. A new pulse needs a return to high and then a new fall.
- R5: A keyboard-controller falling edge detected in a cycle where sleep_trans is high is discarded and is not deferred.
- R6: A request that arrives while a pulse is running neither restarts nor extends it. An int_req held high starts a new pulse one cycle after the previous pulse ends.
- R7: init_fw_n equals init_n in every cycle.
- R8: A rising edge with p92_we high loads bit 1 of p92_wdata into the mask bit. All other bits of p92_wdata are ignored, and the mask bit holds while p92_we is low.
- R9: a20m_n is low exactly when the mask bit is 1 or a20_gate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| int_req | input | 3 | Internal init requests, active high, sampled at each edge |
| kbc_rst_n | input | 1 | Keyboard-controller reset request, active low, asynchronous |
| sleep_trans | input | 1 | High while a sleep-state transition is in progress |
| p92_we | input | 1 | Write strobe for the system-control port |
| p92_wdata | input | 8 | Write data; bit 1 is the mask bit |
| a20_gate | input | 1 | External address-bit-20 gate, active high |
| init_n | output | 1 | Processor init pulse, active low |
| init_fw_n | output | 1 | Identical copy of init_n for the firmware device |
| a20m_n | output | 1 | Address-bit-20 mask, active low |

## Verification
The assertions check the following on every cycle:
- No pulse lasts longer than 16 cycles, and every pulse that ends lasted exactly 16.
- The two init outputs always match.
- An edge dropped during a sleep transition never starts a pulse when it was the only request.
- The gate input always forces the mask output active.
- A port write always lands in the mask bit.

The bench's scenarios are needed to show the following:
- The synchronizer latency of exactly two edges.
- That a long low hold on the keyboard line gives a single pulse.
- That requests arriving in the middle of a pulse are absorbed.
- That a held internal request restarts the pulse after a one-cycle gap.

// File: rtl/cpu_sb_pkg.sv
package cpu_sb_pkg;
  // Position of the mask bit in the system-control port write data.
  localparam int unsigned P92_MASK_BIT = 1;
  localparam int unsigned P92_WIDTH    = 8;
endpackage

// File: rtl/cpu_sb_kb_sync.sv
module cpu_sb_kb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic kb_n_async,
  output logic kb_fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= kb_n_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign kb_fall = s3_q & ~s2_q;

  // R4
  kb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_fall |=> !kb_fall);
endmodule

// File: rtl/cpu_sb_init_pulse.sv
module cpu_sb_init_pulse #(
  parameter int unsigned INIT_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic init_act,
  output logic init_fw_act
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_d;
  logic             act_q, act_fw_q;

  always_comb begin
    if (cnt_q == '0) begin
      cnt_d = req ? CNT_W'(INIT_CYCLES) : '0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_q    <= 1'b0;
      act_fw_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      act_fw_q <= act_d;
    end
  end

  assign init_act    = act_q;
  assign init_fw_act = act_fw_q;

  // Checker: length of the current run of active cycles.
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (act_q)   run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R2
  len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (CNT_W+1)'(INIT_CYCLES));
  // R6
  len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> run_q == (CNT_W+1)'(INIT_CYCLES));
  // R7
  dup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == act_fw_q);
endmodule

// File: rtl/cpu_sb_a20_mask.sv
module cpu_sb_a20_mask
  import cpu_sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [P92_WIDTH-1:0] wr_data,
  input  logic                 gate,
  output logic                 mask_n
);
  logic bit_q, bit_d;

  always_comb begin
    bit_d = bit_q;
    if (wr_en) bit_d = wr_data[P92_MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign mask_n = ~(bit_q | gate);

  // R8
  p92_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bit_q == $past(wr_data[P92_MASK_BIT]));
endmodule

// File: rtl/cpu_init_a20_ctl.sv
module cpu_init_a20_ctl
  import cpu_sb_pkg::*;
#(
  parameter int unsigned NUM_INT_SRC = 3,
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_INT_SRC-1:0] int_req,
  input  logic                   kbc_rst_n,
  input  logic                   sleep_trans,
  input  logic                   p92_we,
  input  logic [P92_WIDTH-1:0]   p92_wdata,
  input  logic                   a20_gate,
  output logic                   init_n,
  output logic                   init_fw_n,
  output logic                   a20m_n
);
  logic kb_fall;
  logic req_any;
  logic init_act, init_fw_act;

  cpu_sb_kb_sync u_kb_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .kb_n_async (kbc_rst_n),
    .kb_fall    (kb_fall)
  );

  assign req_any = (|int_req) | (kb_fall & ~sleep_trans);

  cpu_sb_init_pulse #(.INIT_CYCLES(INIT_CYCLES)) u_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_any),
    .init_act    (init_act),
    .init_fw_act (init_fw_act)
  );

  assign init_n    = ~init_act;
  assign init_fw_n = ~init_fw_act;

  cpu_sb_a20_mask u_a20 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (p92_we),
    .wr_data (p92_wdata),
    .gate    (a20_gate),
    .mask_n  (a20m_n)
  );

  // R5
  sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_fall && sleep_trans && !(|int_req) && !init_act) |=> !init_act);
  // R9
  a20_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a20_gate |-> !a20m_n);
endmodule

// File: tb/tb_cpu_init_a20_ctl.sv
`timescale 1ns/100ps
module tb_cpu_init_a20_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] int_req = '0;
  logic       kbc_rst_n = 1'b1;
  logic       sleep_trans = 1'b0;
  logic       p92_we = 1'b0;
  logic [7:0] p92_wdata = '0;
  logic       a20_gate = 1'b0;
  logic       init_n, init_fw_n, a20m_n;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int last_len = 0;
  int run_len = 0;
  bit prev_low = 1'b0;

  always #2.5 clk = ~clk;

  cpu_init_a20_ctl dut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .kbc_rst_n(kbc_rst_n),
    .sleep_trans(sleep_trans), .p92_we(p92_we), .p92_wdata(p92_wdata),
    .a20_gate(a20_gate), .init_n(init_n), .init_fw_n(init_fw_n), .a20m_n(a20m_n)
  );

  // Behavioural reference model
  logic kq[$] = '{1'b1, 1'b1, 1'b1};
  int   m_cnt = 0;
  bit   m_mask = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kq = '{1'b1, 1'b1, 1'b1};
      m_cnt = 0;
      m_mask = 1'b0;
    end else begin
      bit fall;
      bit req;
      fall = kq[2] && !kq[1];
      req  = (int_req != 0) || (fall && !sleep_trans);
      if (m_cnt == 0) m_cnt = req ? 16 : 0;
      else            m_cnt = m_cnt - 1;
      kq.push_front(kbc_rst_n);
      void'(kq.pop_back());
      if (p92_we) m_mask = p92_wdata[1];
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the edges
  always @(negedge clk) begin
    #1.0;
    if (rst_n) begin
      check("R2/R3 init_n", init_n, (m_cnt == 0));
      check("R7 init_fw_n", init_fw_n, init_n);
      check("R9 a20m_n", a20m_n, !(m_mask || a20_gate));
      if (!init_n) run_len++;
      if (prev_low && init_n) begin
        last_len = run_len;
        pulses++;
        run_len = 0;
      end
      prev_low = !init_n;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    cyc(3);
    rst_n = 1'b1;
    #1.5;
    // R1 reset state
    check("R1 init_n", init_n, 1'b1);
    check("R1 init_fw_n", init_fw_n, 1'b1);
    check("R1 a20m_n", a20m_n, 1'b1);
    cyc(2);

    // R2 internal request, single strobe
    int_req = 3'b010; cyc(1); int_req = '0;
    #1.5; check("R2 low after edge", init_n, 1'b0);
    cyc(20);
    check_int("R2 pulse length", last_len, 16);

    // R3 keyboard latency: low sampled at E0, pulse after E2
    kbc_rst_n = 1'b0; cyc(1);
    #1.5; check("R3 no pulse after E0", init_n, 1'b1);
    cyc(1); #1.5; check("R3 no pulse after E1", init_n, 1'b1);
    cyc(1); #1.5; check("R3 pulse after E2", init_n, 1'b0);
    // R4 hold low long
    p0 = pulses;
    cyc(60);
    check_int("R4 single pulse while held", pulses - p0, 1);
    kbc_rst_n = 1'b1; cyc(5);

    // R5 fall during sleep transition dropped
    p0 = pulses;
    sleep_trans = 1'b1; kbc_rst_n = 1'b0; cyc(6);
    sleep_trans = 1'b0; cyc(25);
    check_int("R5 no pulse during sleep transition", pulses - p0, 0);
    check("R5 init_n idle", init_n, 1'b1);
    kbc_rst_n = 1'b1; cyc(5);

    // R6 absorption mid-pulse
    p0 = pulses;
    int_req = 3'b001; cyc(1); int_req = '0;
    cyc(7); int_req = 3'b100; cyc(1); int_req = '0;
    kbc_rst_n = 1'b0; cyc(2); kbc_rst_n = 1'b1;
    cyc(20);
    check_int("R6 absorbed count", pulses - p0, 1);
    check_int("R6 absorbed length", last_len, 16);

    // R6 held request retriggers after one-cycle gap
    p0 = pulses;
    int_req = 3'b001; cyc(34); int_req = '0; cyc(20);
    check_int("R6 held retrigger pulses", pulses - p0, 2);
    check_int("R6 held retrigger length", last_len, 16);

    // R8 port writes: only bit 1 matters
    p92_wdata = 8'hFD; p92_we = 1'b1; cyc(1); p92_we = 1'b0;
    #1.5; check("R8 other bits ignored", a20m_n, 1'b1);
    p92_wdata = 8'h02; p92_we = 1'b1; cyc(1); p92_we = 1'b0;
    p92_wdata = 8'h00;
    #1.5; check("R8 bit1 sets mask", a20m_n, 1'b0);
    cyc(4); #1.5; check("R8 mask holds", a20m_n, 1'b0);
    // R9 OR with gate
    a20_gate = 1'b1; #0.5; check("R9 both active", a20m_n, 1'b0);
    p92_wdata = 8'h00; p92_we = 1'b1; cyc(1); p92_we = 1'b0;
    #1.5; check("R9 gate alone", a20m_n, 1'b0);
    cyc(1); a20_gate = 1'b0; #0.5; check("R9 neither", a20m_n, 1'b1);
    cyc(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule